// File: doc/BRIEF.md
# Two-Rate ADC Scan Start Sequencer

This block paces analog-to-digital conversions. From its clock it produces a one-cycle start strobe and the index of the channel to convert. The pacing comes from two programmable divisors. The start rate is the clock frequency divided by the divisor.

In per-channel mode, the outer divisor alone sets the rate of every conversion start. The channel index steps through 0 to a programmed last channel and then wraps.

In scan mode, each expiry of the outer divisor begins a scan. The scan's first channel, always channel 0, starts at once. The remaining channels, up to the last channel, follow in ascending order, and the inner divisor sets the spacing between them. A busy flag marks the time during which a scan still has channels left to start.

Top module: `adc_scan_pacer`

## Requirements
- R1: After reset, or from the clock edge that samples `enable` low, `start_stb`, `chan_idx` and `scan_busy` are all 0, and both counters and the channel sequence restart from 0.
- R2: In per-channel mode (`scan_mode`=0) with outer divisor D≥2, the first strobe appears in the cycle after the first edge that samples `enable` high. Later strobes follow exactly every D cycles.
- R3: A divisor value of 0 or 1 behaves as 1: one strobe every cycle in per-channel mode, and back-to-back channel strobes inside a scan.
- R4: In per-channel mode, successive strobes carry channels 0, 1, … up to `last_chan` and then wrap to 0. `chan_idx` is valid while `start_stb` is 1 and holds its value until the next strobe.
- R5: In scan mode, an outer expiry that finds no scan in progress strobes channel 0 in the same cycle as the scan starts. With no dropped expiries, scan starts are D cycles apart.
- R6: Within a scan, channels 1 through the `last_chan` value captured at scan start are strobed in ascending order, each one inner-divisor period after the previous strobe.
- R7: `scan_busy` rises together with a scan's channel-0 strobe when `last_chan`>0. It falls in the cycle that carries the scan's final strobe.
- R8: An outer expiry that occurs while `scan_busy` is 1, including one in the cycle the final strobe is issued, is dropped. The next scan begins at the first later expiry.
- R9: A divisor written while its counter runs does not change the current interval. It takes effect from the next reload.
- R10: A scan with `last_chan`=0 gives one strobe on channel 0 and leaves `scan_busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the sequencer; low clears all state |
| scan_mode | input | 1 | 1 = scan mode, 0 = per-channel mode |
| outer_div | input | 32 | Outer divisor: conversion rate or scan rate |
| inner_div | input | 32 | Inner divisor: spacing of channels within a scan |
| last_chan | input | 3 | Highest channel converted |
| start_stb | output | 1 | One-cycle conversion start |
| chan_idx | output | 3 | Channel of the latest start |
| scan_busy | output | 1 | Scan has channels still to start |

## Verification
Every output is one register away from its inputs. A setting applied at a falling edge therefore shows up on the outputs in the cycle after the next rising edge. Strobe timing is counted from there: the first strobe lands in sample 0, and the following ones land at exact multiples of the active divisor. The bench builds an expected per-cycle trace of strobe, channel and busy from the divisor arithmetic. This includes working out which outer expiries land inside a running scan and are dropped. The bench then compares the trace against the outputs sampled at each falling edge, so a strobe that arrives one cycle early or late is a miscompare. A divisor change is applied mid-interval, and the bench expects the old interval to finish before the new one starts.

// File: rtl/adc_scan_pacer.sv
module adc_scan_pacer #(
  parameter int DIV_W = 32,
  parameter int CH_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             scan_mode,
  input  logic [DIV_W-1:0] outer_div,
  input  logic [DIV_W-1:0] inner_div,
  input  logic [CH_W-1:0]  last_chan,
  output logic             start_stb,
  output logic [CH_W-1:0]  chan_idx,
  output logic             scan_busy
);

  logic [DIV_W-1:0] o_cnt, i_cnt;
  logic [CH_W-1:0]  nxt, last_q;

  wire [DIV_W-1:0] o_load = (outer_div == '0) ? '0 : outer_div - 1'b1;
  wire [DIV_W-1:0] i_load = (inner_div == '0) ? '0 : inner_div - 1'b1;
  wire             o_tick = (o_cnt == '0);
  wire             i_tick = (i_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_cnt <= '0; i_cnt <= '0; nxt <= '0; last_q <= '0;
      start_stb <= 1'b0; chan_idx <= '0; scan_busy <= 1'b0;
    end else if (!enable) begin
      o_cnt <= '0; i_cnt <= '0; nxt <= '0; last_q <= '0;
      start_stb <= 1'b0; chan_idx <= '0; scan_busy <= 1'b0;
    end else begin
      start_stb <= 1'b0;
      o_cnt <= o_tick ? o_load : o_cnt - 1'b1;
      if (!scan_mode) begin
        scan_busy <= 1'b0;
        i_cnt <= '0;
        if (o_tick) begin
          start_stb <= 1'b1;
          chan_idx  <= nxt;
          nxt       <= (nxt >= last_chan) ? '0 : nxt + 1'b1;
        end
      end else if (scan_busy) begin
        if (i_tick) begin
          start_stb <= 1'b1;
          chan_idx  <= nxt;
          if (nxt >= last_q) scan_busy <= 1'b0;
          else begin
            nxt   <= nxt + 1'b1;
            i_cnt <= i_load;
          end
        end else begin
          i_cnt <= i_cnt - 1'b1;
        end
      end else if (o_tick) begin
        start_stb <= 1'b1;
        chan_idx  <= '0;
        last_q    <= last_chan;
        nxt       <= {{(CH_W-1){1'b0}}, 1'b1};
        i_cnt     <= i_load;
        scan_busy <= (last_chan != '0);
      end
    end
  end

  // R1
  stb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!start_stb && !scan_busy && chan_idx == '0));

  // R5
  scan_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_busy) |-> (start_stb && chan_idx == '0));

  // R6
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stb && scan_busy && $past(scan_busy)) |-> (chan_idx == $past(chan_idx) + 1'b1));

  // R7
  scan_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scan_busy) && $past(enable) && $past(scan_mode)) |-> start_stb);

endmodule

// File: tb/adc_scan_pacer_tb.sv
module adc_scan_pacer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic scan_mode = 1'b0;
  logic [31:0] outer_div = 32'd4;
  logic [31:0] inner_div = 32'd1;
  logic [2:0]  last_chan = 3'd0;
  logic        start_stb, scan_busy;
  logic [2:0]  chan_idx;

  int n_chk = 0;
  int n_bad = 0;

  bit       exp_s [0:255];
  bit [2:0] exp_c [0:255];
  bit       exp_b [0:255];

  always #2 clk = ~clk;

  adc_scan_pacer u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scan_mode(scan_mode),
    .outer_div(outer_div), .inner_div(inner_div), .last_chan(last_chan),
    .start_stb(start_stb), .chan_idx(chan_idx), .scan_busy(scan_busy)
  );

  function automatic int eff(input int d);
    return (d < 2) ? 1 : d;
  endfunction

  task automatic clear_exp();
    for (int i = 0; i < 256; i++) begin
      exp_s[i] = 1'b0; exp_c[i] = 3'd0; exp_b[i] = 1'b0;
    end
  endtask

  task automatic check(input string tag, input int act, input int exp, input string what, input int cyc);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at sample %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic gen_pc(input int d, input int last, input int n);
    int k = 0;
    clear_exp();
    for (int t = 0; t < n; t += eff(d)) begin
      exp_s[t] = 1'b1; exp_c[t] = 3'(k % (last + 1)); k++;
    end
  endtask

  task automatic gen_scan(input int d, input int di, input int last, input int n);
    int s = 0;
    int fin;
    clear_exp();
    while (s < n) begin
      for (int j = 0; j <= last; j++)
        if (s + j * eff(di) < n) begin
          exp_s[s + j * eff(di)] = 1'b1; exp_c[s + j * eff(di)] = 3'(j);
        end
      fin = s + last * eff(di);
      for (int t = s; t < fin && t < n; t++) exp_b[t] = 1'b1;
      s = (fin / eff(d) + 1) * eff(d);
    end
  endtask

  task automatic start_run(input bit scan, input int d, input int di, input int last);
    @(negedge clk);
    enable = 1'b0;
    scan_mode = scan; outer_div = d; inner_div = di; last_chan = 3'(last);
    @(negedge clk);
    check("R1", start_stb, 0, "idle strobe", -1);
    check("R1", scan_busy, 0, "idle busy", -1);
    check("R1", chan_idx, 0, "idle channel", -1);
    enable = 1'b1;
  endtask

  task automatic run_cmp(input int n, input string tag, input int chg_at, input int chg_val);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, start_stb, exp_s[i], "strobe", i);
      if (exp_s[i]) check(tag, chan_idx, exp_c[i], "channel", i);
      check(tag, scan_busy, exp_b[i], "busy", i);
      if (i == chg_at) outer_div = chg_val;
    end
  endtask

  task automatic t_per_channel();
    start_run(1'b0, 4, 1, 2);
    gen_pc(4, 2, 40);
    run_cmp(40, "R2 R4", -1, 0);
  endtask

  task automatic t_fast();
    start_run(1'b0, 0, 1, 0);
    gen_pc(0, 0, 12);
    run_cmp(12, "R3", -1, 0);
    start_run(1'b0, 1, 1, 7);
    gen_pc(1, 7, 20);
    run_cmp(20, "R3 R4", -1, 0);
  endtask

  task automatic t_scan();
    start_run(1'b1, 40, 3, 3);
    gen_scan(40, 3, 3, 130);
    run_cmp(130, "R5 R6 R7", -1, 0);
  endtask

  task automatic t_overlap();
    start_run(1'b1, 5, 4, 2);
    gen_scan(5, 4, 2, 80);
    run_cmp(80, "R8", -1, 0);
    start_run(1'b1, 6, 3, 2);
    gen_scan(6, 3, 2, 60);
    run_cmp(60, "R8", -1, 0);
  endtask

  task automatic t_single();
    start_run(1'b1, 3, 5, 0);
    gen_scan(3, 5, 0, 30);
    run_cmp(30, "R10", -1, 0);
  endtask

  task automatic t_back_to_back();
    start_run(1'b1, 20, 0, 7);
    gen_scan(20, 0, 7, 60);
    run_cmp(60, "R3 R6", -1, 0);
  endtask

  task automatic t_reload();
    start_run(1'b0, 5, 1, 7);
    clear_exp();
    exp_s[0] = 1; exp_c[0] = 0;
    exp_s[5] = 1; exp_c[5] = 1;
    for (int k = 0; 10 + 3 * k < 30; k++) begin
      exp_s[10 + 3 * k] = 1; exp_c[10 + 3 * k] = 3'(k + 2);
    end
    run_cmp(30, "R9", 6, 3);
  endtask

  task automatic t_abort();
    start_run(1'b1, 50, 4, 5);
    gen_scan(50, 4, 5, 6);
    run_cmp(6, "R5", -1, 0);
    enable = 1'b0;
    @(negedge clk);
    check("R1", start_stb, 0, "strobe after disable", 0);
    check("R1", scan_busy, 0, "busy after disable", 0);
    check("R1", chan_idx, 0, "channel after disable", 0);
    enable = 1'b1;
    gen_scan(50, 4, 5, 30);
    run_cmp(30, "R1", -1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", start_stb, 0, "reset strobe", -1);
    check("R1", scan_busy, 0, "reset busy", -1);
    check("R1", chan_idx, 0, "reset channel", -1);
    rst_n = 1'b1;
    t_per_channel();
    t_fast();
    t_scan();
    t_overlap();
    t_single();
    t_back_to_back();
    t_reload();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule